// File: doc/BRIEF.md
# Stepwise Voltage/Frequency Level Sequencer for a Serial Link

This block moves one serial link between ten discrete operating points, level 0 being the fastest and highest-voltage point and level 9 the slowest and lowest-voltage point. A separate policy block chooses a target level. This block walks the link there one adjacent level at a time. It never jumps over a level. Within each step it orders the clock change and the supply change by direction. Each change is held for its own settling time before the next action.

The frequency and voltage indices go to the clock generator and the regulator. The `link_blocked` flag tells the flit sender that the link clock is moving, so no flit may be launched. While the supply is settling, the link keeps carrying traffic at the frequency in force. A `busy` flag and a one-cycle `done` pulse report progress to the policy side.

Top module: `dvs_level_seq`

## Requirements
- R1: After reset both indices are 0, and `link_blocked`, `busy` and `done` are low while the target is 0.
- R2: The target is a 4-bit level code. Codes above 9 are treated as 9.
- R3: Each index changes by exactly one level at a time, and a move of k levels passes through every level in between. The two indices never differ by more than one.
- R4: When slowing down by one level (index rising), `freq_idx` changes one cycle after the step starts. `volt_idx` follows FREQ_SETTLE cycles later.
- R5: When speeding up by one level (index falling), `volt_idx` changes one cycle after the step starts. `freq_idx` follows VOLT_SETTLE cycles later.
- R6: `link_blocked` is high for exactly FREQ_SETTLE cycles per frequency change, and low during voltage settling.
- R7: One step, from the cycle the sequencer sees the differing target to the `done` pulse, takes 1+FREQ_SETTLE+VOLT_SETTLE cycles. A move of k levels takes k times that.
- R8: A target change during a step lets that step finish. The next step is then chosen from the new target.
- R9: `busy` stays high from the start of a move until the indices equal the target. `done` is a single-cycle pulse, raised only when the landed level equals the target.
- R10: A target equal to the current level causes no index change, no `busy` and no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tgt_level | input | IDX_W | Requested level (0 fastest, 9 slowest) |
| freq_idx | output | IDX_W | Frequency level applied to the clock generator |
| volt_idx | output | IDX_W | Voltage level applied to the regulator |
| link_blocked | output | 1 | High while the frequency settles; no flit may cross |
| busy | output | 1 | A move toward the target is in progress |
| done | output | 1 | One-cycle pulse when the target level is reached |

## Verification
The bench builds the sequencer with FREQ_SETTLE=3 and VOLT_SETTLE=7 and keeps the ten levels. A full 0-to-9 sweep then costs 99 cycles, so several full sweeps, a saturated target and a mid-step retarget all fit in one short run. Because the two settle times are unequal, a swapped ordering or a swapped settle length shows up as a wrong cycle count for the index change or for the blocked window.

// File: rtl/dvs_seq_pkg.sv
package dvs_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_FREQ = 2'd1,
    PH_VOLT = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_SLOW = 2'd1,
    DIR_FAST = 2'd2
  } dir_e;

  // Requested level saturated to the slowest legal level.
  function automatic int sat_level(input int req, input int last);
    return (req > last) ? last : req;
  endfunction

  // Settle length of a phase: frequency or voltage.
  function automatic int phase_len(input bit is_freq, input int f_len, input int v_len);
    return is_freq ? f_len : v_len;
  endfunction

  // Whether the first phase of a step in this direction moves the clock.
  function automatic bit freq_first(input dir_e d);
    return (d == DIR_SLOW);
  endfunction

endpackage

// File: rtl/dvs_settle_timer.sv
module dvs_settle_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/dvs_step_planner.sv
module dvs_step_planner
  import dvs_seq_pkg::*;
#(
  parameter int NUM_LEVELS = 10,
  parameter int IDX_W      = 4
) (
  input  logic [IDX_W-1:0] cur_lvl,
  input  logic [IDX_W-1:0] req_lvl,
  output logic [IDX_W-1:0] tgt_sat,
  output dir_e             plan_dir,
  output logic [IDX_W-1:0] plan_next
);

  localparam int LAST = NUM_LEVELS - 1;

  always_comb begin
    tgt_sat = IDX_W'(sat_level(int'(req_lvl), LAST));
    if (tgt_sat > cur_lvl) begin
      plan_dir  = DIR_SLOW;
      plan_next = cur_lvl + 1'b1;
    end else if (tgt_sat < cur_lvl) begin
      plan_dir  = DIR_FAST;
      plan_next = cur_lvl - 1'b1;
    end else begin
      plan_dir  = DIR_HOLD;
      plan_next = cur_lvl;
    end
  end

endmodule

// File: rtl/dvs_phase_ctrl.sv
module dvs_phase_ctrl
  import dvs_seq_pkg::*;
#(
  parameter int IDX_W       = 4,
  parameter int FREQ_SETTLE = 20,
  parameter int VOLT_SETTLE = 100,
  parameter int CNT_W       = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dir_e             plan_dir,
  input  logic [IDX_W-1:0] plan_next,
  input  logic [IDX_W-1:0] tgt_sat,
  input  logic             tmr_expired,
  output logic [IDX_W-1:0] lvl_f,
  output logic [IDX_W-1:0] lvl_v,
  output phase_e           phase,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             done
);

  phase_e           phase_q;
  dir_e             sdir_q;
  logic             second_q;
  logic [IDX_W-1:0] lvl_f_q, lvl_v_q, dest_q;
  logic             done_q;

  // Named events for the timer and for observation.
  logic step_start, phase_end, first_end, step_end;

  assign step_start = (phase_q == PH_IDLE) && (plan_dir != DIR_HOLD);
  assign phase_end  = (phase_q != PH_IDLE) && tmr_expired;
  assign first_end  = phase_end && !second_q;
  assign step_end   = phase_end && second_q;

  always_comb begin
    tmr_load = step_start || first_end;
    if (step_start) begin
      tmr_val = CNT_W'(phase_len(freq_first(plan_dir), FREQ_SETTLE, VOLT_SETTLE) - 1);
    end else begin
      tmr_val = CNT_W'(phase_len(!freq_first(sdir_q), FREQ_SETTLE, VOLT_SETTLE) - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      sdir_q   <= DIR_HOLD;
      second_q <= 1'b0;
      lvl_f_q  <= '0;
      lvl_v_q  <= '0;
      dest_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (step_start) begin
        sdir_q   <= plan_dir;
        dest_q   <= plan_next;
        second_q <= 1'b0;
        if (freq_first(plan_dir)) begin
          lvl_f_q <= plan_next;
          phase_q <= PH_FREQ;
        end else begin
          lvl_v_q <= plan_next;
          phase_q <= PH_VOLT;
        end
      end else if (first_end) begin
        second_q <= 1'b1;
        if (freq_first(sdir_q)) begin
          lvl_v_q <= dest_q;
          phase_q <= PH_VOLT;
        end else begin
          lvl_f_q <= dest_q;
          phase_q <= PH_FREQ;
        end
      end else if (step_end) begin
        second_q <= 1'b0;
        phase_q  <= PH_IDLE;
        done_q   <= (dest_q == tgt_sat);
      end
    end
  end

  assign lvl_f = lvl_f_q;
  assign lvl_v = lvl_v_q;
  assign phase = phase_q;
  assign done  = done_q;

endmodule

// File: rtl/dvs_level_seq.sv
module dvs_level_seq
  import dvs_seq_pkg::*;
#(
  parameter int NUM_LEVELS  = 10,
  parameter int IDX_W       = 4,
  parameter int FREQ_SETTLE = 20,
  parameter int VOLT_SETTLE = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] tgt_level,
  output logic [IDX_W-1:0] freq_idx,
  output logic [IDX_W-1:0] volt_idx,
  output logic             link_blocked,
  output logic             busy,
  output logic             done
);

  localparam int MAX_SETTLE = (FREQ_SETTLE > VOLT_SETTLE) ? FREQ_SETTLE : VOLT_SETTLE;
  localparam int CNT_W      = $clog2(MAX_SETTLE + 1);

  logic [IDX_W-1:0] tgt_sat, plan_next, lvl_f, lvl_v;
  dir_e             plan_dir;
  phase_e           phase;
  logic             tmr_load, tmr_expired;
  logic [CNT_W-1:0] tmr_val;

  dvs_step_planner #(
    .NUM_LEVELS(NUM_LEVELS),
    .IDX_W     (IDX_W)
  ) u_plan (
    .cur_lvl  (lvl_v),
    .req_lvl  (tgt_level),
    .tgt_sat  (tgt_sat),
    .plan_dir (plan_dir),
    .plan_next(plan_next)
  );

  dvs_settle_timer #(
    .CNT_W(CNT_W)
  ) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );

  dvs_phase_ctrl #(
    .IDX_W      (IDX_W),
    .FREQ_SETTLE(FREQ_SETTLE),
    .VOLT_SETTLE(VOLT_SETTLE),
    .CNT_W      (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .plan_dir   (plan_dir),
    .plan_next  (plan_next),
    .tgt_sat    (tgt_sat),
    .tmr_expired(tmr_expired),
    .lvl_f      (lvl_f),
    .lvl_v      (lvl_v),
    .phase      (phase),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .done       (done)
  );

  assign freq_idx     = lvl_f;
  assign volt_idx     = lvl_v;
  assign link_blocked = (phase == PH_FREQ);
  assign busy         = (phase != PH_IDLE) || (lvl_v != tgt_sat);

endmodule

// File: rtl/dvs_level_seq_chk.sv
module dvs_level_seq_chk #(
  parameter int NUM_LEVELS = 10,
  parameter int IDX_W      = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] freq_idx,
  input logic [IDX_W-1:0] volt_idx,
  input logic             link_blocked,
  input logic             busy,
  input logic             done
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_LEVELS - 1);

  a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_idx <= LAST) && (volt_idx <= LAST));

  a_r3_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_idx == volt_idx) || (freq_idx == volt_idx + 1'b1) || (volt_idx == freq_idx + 1'b1));

  a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_idx != $past(freq_idx)) |->
      ((freq_idx == $past(freq_idx) + 1'b1) || ($past(freq_idx) == freq_idx + 1'b1)));

  a_r4_volt_after_freq: assert property (@(posedge clk) disable iff (!rst_n)
    (volt_idx > $past(volt_idx)) |-> (freq_idx == volt_idx));

  a_r5_freq_after_volt: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_idx < $past(freq_idx)) |-> (freq_idx == volt_idx));

  a_r6_volt_still_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (link_blocked && $past(link_blocked)) |-> $stable(volt_idx));

  a_r9_blocked_is_busy: assert property (@(posedge clk) disable iff (!rst_n)
    link_blocked |-> busy);

  a_r9_done_settled: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((freq_idx == volt_idx) && !link_blocked));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind dvs_level_seq dvs_level_seq_chk #(
  .NUM_LEVELS(NUM_LEVELS),
  .IDX_W     (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .freq_idx    (freq_idx),
  .volt_idx    (volt_idx),
  .link_blocked(link_blocked),
  .busy        (busy),
  .done        (done)
);

// File: tb/tb_dvs_level_seq.sv
module tb_dvs_level_seq;

  localparam int F    = 3;
  localparam int V    = 7;
  localparam int STEP = 1 + F + V;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] tgt = 4'd0;
  logic [3:0] freq_idx, volt_idx;
  logic       link_blocked, busy, done;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  dvs_level_seq #(
    .NUM_LEVELS (10),
    .IDX_W      (4),
    .FREQ_SETTLE(F),
    .VOLT_SETTLE(V)
  ) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tgt_level   (tgt),
    .freq_idx    (freq_idx),
    .volt_idx    (volt_idx),
    .link_blocked(link_blocked),
    .busy        (busy),
    .done        (done)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog: run hung act=%0d exp<=20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(freq_idx == 0, "R1", "freq after reset", freq_idx, 0);
    chk(volt_idx == 0, "R1", "volt after reset", volt_idx, 0);
    chk({link_blocked, busy, done} == 3'b000, "R1", "flags after reset",
        {link_blocked, busy, done}, 0);
  endtask

  task automatic t_hold_same();
    int act = 0;
    @(negedge clk);
    tgt = 4'd0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (busy || done || link_blocked || freq_idx != 0 || volt_idx != 0) act++;
    end
    chk(act == 0, "R10", "activity with target equal to level", act, 0);
  endtask

  // One adjacent step; records when each index moves.
  task automatic t_one_step(input int from, input int to);
    int fchg = 0, vchg = 0, blk = 0, busy_lo = 0, dn = 0;
    bit slow = (to > from);
    @(negedge clk);
    tgt = 4'(to);
    for (int n = 1; n <= STEP; n++) begin
      @(negedge clk);
      if (fchg == 0 && freq_idx != 4'(from)) fchg = n;
      if (vchg == 0 && volt_idx != 4'(from)) vchg = n;
      if (link_blocked) begin
        blk++;
        if (volt_idx != (slow ? 4'(from) : 4'(to))) blk += 100;
      end
      if (!busy && n < STEP) busy_lo++;
      if (done && dn == 0) dn = n;
    end
    if (slow) begin
      chk(fchg == 1, "R4", "slow: freq move cycle", fchg, 1);
      chk(vchg == F + 1, "R4", "slow: volt move cycle", vchg, F + 1);
    end else begin
      chk(vchg == 1, "R5", "fast: volt move cycle", vchg, 1);
      chk(fchg == V + 1, "R5", "fast: freq move cycle", fchg, V + 1);
    end
    chk(blk == F, "R6", "blocked cycles in step", blk, F);
    chk(dn == STEP, "R7", "single step duration", dn, STEP);
    chk(busy_lo == 0, "R9", "busy low during step", busy_lo, 0);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done pulse width", done, 0);
    chk(freq_idx == 4'(to) && volt_idx == 4'(to), "R3", "landed level",
        freq_idx, to);
  endtask

  // Multi-level move; tracks path and timing.
  task automatic t_move(input int code, input int levels, input int final_lvl,
                        input string req);
    int n = 0, moves = 0, bad = 0, busy_lo = 0;
    logic [3:0] prev_f;
    @(negedge clk);
    tgt = 4'(code);
    prev_f = freq_idx;
    do begin
      @(negedge clk);
      n++;
      if (freq_idx != prev_f) begin
        moves++;
        if (!((freq_idx == prev_f + 4'd1) || (prev_f == freq_idx + 4'd1))) bad++;
      end
      prev_f = freq_idx;
      if (!busy && !done) busy_lo++;
    end while (!done && n < 400);
    chk(n == levels * STEP, "R7", "multi-level duration", n, levels * STEP);
    chk(moves == levels && bad == 0, "R3", "freq moves one level at a time",
        moves + 100 * bad, levels);
    chk(volt_idx == 4'(final_lvl) && freq_idx == 4'(final_lvl), req,
        "final level", volt_idx, final_lvl);
    chk(busy_lo == 0, "R9", "busy gaps during move", busy_lo, 0);
    @(negedge clk);
    chk(busy == 1'b0, "R9", "busy after arrival", busy, 0);
  endtask

  task automatic t_retarget();
    int n = 0, maxf = 0, early_done = 0;
    @(negedge clk);
    tgt = 4'd5;
    do begin
      @(negedge clk);
      n++;
      if (int'(freq_idx) > maxf) maxf = int'(freq_idx);
      if (done && n < 2 * STEP) early_done++;
      if (n == 3) tgt = 4'd0;
    end while (!done && n < 400);
    chk(maxf == 1, "R8", "highest level reached", maxf, 1);
    chk(n == 2 * STEP, "R8", "retarget completion cycle", n, 2 * STEP);
    chk(early_done == 0, "R9", "done only at target", early_done, 0);
    chk(volt_idx == 0 && freq_idx == 0, "R8", "level after retarget", volt_idx, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hold_same();
    t_one_step(0, 1);
    t_one_step(1, 0);
    t_move(9, 9, 9, "R3");
    t_move(0, 9, 0, "R3");
    t_move(15, 9, 9, "R2");
    t_move(0, 9, 0, "R2");
    t_move(12, 9, 9, "R2");
    t_move(4, 5, 4, "R7");
    t_move(0, 4, 0, "R7");
    t_retarget();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule